// File: doc/BRIEF.md
# Frame-Gated Gamma Correction Stage

This block sits in a packetised video stream and replaces every colour sample of a video frame with an entry from a programmable look-up table. Each input beat carries `NUM_CH` samples of `SAMPLE_W` bits each. The first beat of every packet holds a packet type in its low 4 bits. Type 0 marks a video frame. Any other type marks a packet that is not video, and such a packet is forwarded unchanged.

A run bit in a small register slave decides whether the stage takes in video. The block samples this bit only at the head of a video packet. If the bit is clear, the head beat is held at the input and is not dropped. A running frame always finishes, even when the run bit is cleared partway through it. A status bit shows whether the stage is running. Software can therefore clear the run bit, wait until status reads 0, rewrite the table, and set the run bit again. The table is then never changed while a frame is being processed.

Top module: `gamma_stage`

## Requirements
- R1: After reset, the output valid is 0, the run bit reads 0, status reads 0, and every table entry holds its own index (identity mapping).
- R2: Register reads return data on `rdata_o` in the cycle after the read strobe. Offset 0 holds the run bit in bit 0 and is read/write. Offset 1 holds status in bit 0, and writes to offset 1 are ignored.
- R3: Register offsets 2 to 2+2^SAMPLE_W-1 are the table entries. Entry k sits at offset k+2, is SAMPLE_W bits wide, and can be written and read back.
- R4: A packet head beat with type 0 is accepted only while the run bit is 1. Otherwise `s_rdy_o` stays 0, the beat is held without loss, and it is taken once the run bit is set.
- R5: A packet whose head type is not 0 is forwarded beat for beat with its data unchanged, whatever the run bit holds.
- R6: Every beat leaves one cycle after it is accepted. On each non-head beat of a video packet, each sample s is replaced by table[s]. Head beats pass through unchanged. Start and end markers stay aligned with their data.
- R7: Clearing the run bit during a video frame does not cut the frame short. All of its beats are still processed, and the next video frame is held.
- R8: Status rises only when a video head beat is accepted. It falls only after the run bit has been cleared, once the current frame has ended. It stays 1 between frames while the run bit remains 1.
- R9: While `m_vld_o` is 1 and `m_rdy_i` is 0, the output beat and its markers hold steady, and no beat is lost or duplicated.
- R10: Table writes made while status is 1 are accepted, and they apply to video beats accepted after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_vld_i | input | 1 | Input beat valid |
| s_rdy_o | output | 1 | Input beat ready |
| s_data_i | input | NUM_CH*SAMPLE_W | Input samples; packet type in bits 3:0 of a head beat |
| s_sop_i | input | 1 | Input start of packet |
| s_eop_i | input | 1 | Input end of packet |
| m_vld_o | output | 1 | Output beat valid |
| m_rdy_i | input | 1 | Output beat ready |
| m_data_o | output | NUM_CH*SAMPLE_W | Output samples |
| m_sop_o | output | 1 | Output start of packet |
| m_eop_o | output | 1 | Output end of packet |
| cs_i | input | 1 | Register chip select |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register offset |
| wdata_i | input | SAMPLE_W | Register write data |
| rdata_o | output | SAMPLE_W | Register read data |

## Verification
The bench uses SAMPLE_W = 8 with two samples per beat. This gives the full 256-entry table and a 9-bit offset space, so both the lowest and the highest table offsets are written and read back. With two lanes per beat, the bench can show that each lane does its own lookup in the shared table. Random output backpressure, frames of up to 16 pixel beats, and a run bit cleared in mid-frame reach the held-head, stalled-output and late-status cases.

// File: rtl/gamma_pkg.sv
package gamma_pkg;
  localparam int unsigned CTRL_OFS = 0;
  localparam int unsigned STAT_OFS = 1;
  localparam int unsigned TBL_BASE = 2;
  localparam int unsigned TYPE_W   = 4;
  localparam logic [TYPE_W-1:0] TYPE_VIDEO = '0;

  typedef enum logic [1:0] {
    ST_HEAD,
    ST_PASS,
    ST_VIDEO
  } pkt_state_e;
endpackage

// File: rtl/gamma_lut.sv
module gamma_lut #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned NUM_CH   = 3
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [SAMPLE_W-1:0]        idx_i,
  input  logic [SAMPLE_W-1:0]        wdata_i,
  output logic [SAMPLE_W-1:0]        rdata_o,
  input  logic [NUM_CH*SAMPLE_W-1:0] lk_in_i,
  output logic [NUM_CH*SAMPLE_W-1:0] lk_out_o
);
  localparam int unsigned DEPTH = 1 << SAMPLE_W;

  logic [SAMPLE_W-1:0] tbl_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 tbl_q[g] <= SAMPLE_W'(g);
      else if (we_i && idx_i == SAMPLE_W'(g))      tbl_q[g] <= wdata_i;
    end
  end

  assign rdata_o = tbl_q[idx_i];

  // one read port per lane
  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    assign lk_out_o[c*SAMPLE_W +: SAMPLE_W] = tbl_q[lk_in_i[c*SAMPLE_W +: SAMPLE_W]];
  end
endmodule

// File: rtl/gamma_regs.sv
module gamma_regs
  import gamma_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned ADDR_W   = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                cs_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SAMPLE_W-1:0] wdata_i,
  input  logic                status_i,
  input  logic [SAMPLE_W-1:0] tbl_rdata_i,
  output logic                go_o,
  output logic [SAMPLE_W-1:0] rdata_o,
  output logic                tbl_we_o,
  output logic [SAMPLE_W-1:0] tbl_idx_o
);
  localparam int unsigned DEPTH = 1 << SAMPLE_W;

  logic is_ctrl, is_stat, is_tbl, go_q;
  logic [SAMPLE_W-1:0] rdata_q;

  assign is_ctrl   = addr_i == ADDR_W'(CTRL_OFS);
  assign is_stat   = addr_i == ADDR_W'(STAT_OFS);
  assign is_tbl    = (32'(addr_i) >= TBL_BASE) && (32'(addr_i) < TBL_BASE + DEPTH);
  assign tbl_idx_o = SAMPLE_W'(addr_i - ADDR_W'(TBL_BASE));
  assign tbl_we_o  = cs_i && wr_i && is_tbl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     go_q <= 1'b0;
    else if (cs_i && wr_i && is_ctrl) go_q <= wdata_i[0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (cs_i && rd_i) begin
      if (is_ctrl)      rdata_q <= SAMPLE_W'(go_q);
      else if (is_stat) rdata_q <= SAMPLE_W'(status_i);
      else if (is_tbl)  rdata_q <= tbl_rdata_i;
      else              rdata_q <= '0;
    end
  end

  assign go_o    = go_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/gamma_ctrl.sv
module gamma_ctrl
  import gamma_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic       acc_i,
  input  logic       head_video_i,
  input  logic       eop_i,
  output pkt_state_e state_o,
  output logic       status_o
);
  pkt_state_e state_q;
  logic       status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HEAD;
      status_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_HEAD: begin
          if (acc_i && head_video_i) begin
            status_q <= 1'b1;
            state_q  <= eop_i ? ST_HEAD : ST_VIDEO;
          end else begin
            if (!go_i) status_q <= 1'b0;
            if (acc_i && !eop_i) state_q <= ST_PASS;
          end
        end
        ST_PASS: begin
          if (!go_i) status_q <= 1'b0;
          if (acc_i && eop_i) state_q <= ST_HEAD;
        end
        ST_VIDEO: begin
          // frame always runs to its end
          if (acc_i && eop_i) begin
            state_q  <= ST_HEAD;
            status_q <= go_i;
          end
        end
        default: state_q <= ST_HEAD;
      endcase
    end
  end

  assign state_o  = state_q;
  assign status_o = status_q;
endmodule

// File: rtl/gamma_pipe.sv
module gamma_pipe #(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned NUM_CH   = 3,
  localparam int unsigned BEAT_W  = SAMPLE_W * NUM_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              map_en_i,
  input  logic [BEAT_W-1:0] raw_i,
  input  logic [BEAT_W-1:0] lk_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic              rdy_i,
  output logic              free_o,
  output logic              vld_o,
  output logic [BEAT_W-1:0] data_o,
  output logic              sop_o,
  output logic              eop_o
);
  logic              vld_q, sop_q, eop_q;
  logic [BEAT_W-1:0] data_q;

  assign free_o = !vld_q || rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      sop_q  <= 1'b0;
      eop_q  <= 1'b0;
      data_q <= '0;
    end else if (free_o) begin
      vld_q <= acc_i;
      if (acc_i) begin
        data_q <= map_en_i ? lk_i : raw_i;
        sop_q  <= sop_i;
        eop_q  <= eop_i;
      end
    end
  end

  assign vld_o  = vld_q;
  assign data_o = data_q;
  assign sop_o  = sop_q;
  assign eop_o  = eop_q;
endmodule

// File: rtl/gamma_stage.sv
module gamma_stage
  import gamma_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned ADDR_W   = $clog2(TBL_BASE + (1 << SAMPLE_W)),
  localparam int unsigned BEAT_W  = SAMPLE_W * NUM_CH
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                s_vld_i,
  output logic                s_rdy_o,
  input  logic [BEAT_W-1:0]   s_data_i,
  input  logic                s_sop_i,
  input  logic                s_eop_i,
  output logic                m_vld_o,
  input  logic                m_rdy_i,
  output logic [BEAT_W-1:0]   m_data_o,
  output logic                m_sop_o,
  output logic                m_eop_o,
  input  logic                cs_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [SAMPLE_W-1:0] wdata_i,
  output logic [SAMPLE_W-1:0] rdata_o
);
  logic                go, status, free, acc, head_video, hold_head, tbl_we;
  logic [SAMPLE_W-1:0] tbl_idx, tbl_rdata;
  logic [BEAT_W-1:0]   lk_data;
  pkt_state_e          pkt_state;

  assign head_video = s_data_i[TYPE_W-1:0] == TYPE_VIDEO;
  // video head waits here while stopped
  assign hold_head  = (pkt_state == ST_HEAD) && head_video && !go;
  assign s_rdy_o    = free && !hold_head;
  assign acc        = s_vld_i && s_rdy_o;

  gamma_regs #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W)) i_regs (
    .clk_i, .rst_ni, .cs_i, .rd_i, .wr_i, .addr_i, .wdata_i,
    .status_i    (status),
    .tbl_rdata_i (tbl_rdata),
    .go_o        (go),
    .rdata_o,
    .tbl_we_o    (tbl_we),
    .tbl_idx_o   (tbl_idx)
  );

  gamma_lut #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) i_lut (
    .clk_i, .rst_ni,
    .we_i     (tbl_we),
    .idx_i    (tbl_idx),
    .wdata_i  (wdata_i),
    .rdata_o  (tbl_rdata),
    .lk_in_i  (s_data_i),
    .lk_out_o (lk_data)
  );

  gamma_ctrl i_ctrl (
    .clk_i, .rst_ni,
    .go_i         (go),
    .acc_i        (acc),
    .head_video_i (head_video),
    .eop_i        (s_eop_i),
    .state_o      (pkt_state),
    .status_o     (status)
  );

  gamma_pipe #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH)) i_pipe (
    .clk_i, .rst_ni,
    .acc_i    (acc),
    .map_en_i (pkt_state == ST_VIDEO),
    .raw_i    (s_data_i),
    .lk_i     (lk_data),
    .sop_i    (s_sop_i),
    .eop_i    (s_eop_i),
    .rdy_i    (m_rdy_i),
    .free_o   (free),
    .vld_o    (m_vld_o),
    .data_o   (m_data_o),
    .sop_o    (m_sop_o),
    .eop_o    (m_eop_o)
  );
endmodule

// File: rtl/gamma_stage_chk.sv
module gamma_stage_chk
  import gamma_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned NUM_CH   = 3,
  parameter int unsigned ADDR_W   = 9,
  localparam int unsigned BEAT_W  = SAMPLE_W * NUM_CH
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                s_vld_i,
  input logic                s_rdy_o,
  input logic                m_vld_o,
  input logic                m_rdy_i,
  input logic [BEAT_W-1:0]   m_data_o,
  input logic                m_sop_o,
  input logic                m_eop_o,
  input logic                cs_i,
  input logic                rd_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic [SAMPLE_W-1:0] rdata_o,
  input logic                go,
  input logic                status,
  input pkt_state_e          pkt_state
);
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_vld_o && !m_rdy_i |=> m_vld_o && $stable(m_data_o) && $stable(m_sop_o) && $stable(m_eop_o)); // R9

  AST_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    s_vld_i && s_rdy_o |=> m_vld_o); // R6

  AST_NO_START_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_state == ST_HEAD && !go |=> pkt_state != ST_VIDEO); // R4

  AST_STATUS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status) |-> $past(pkt_state) == ST_HEAD && $past(go)); // R8

  AST_STATUS_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status) |-> !$past(go)); // R8

  AST_FRAME_RUNS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_state == ST_VIDEO |-> status); // R7

  AST_STAT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_i && rd_i && addr_i == ADDR_W'(STAT_OFS) |=> rdata_o == SAMPLE_W'($past(status))); // R2
endmodule

bind gamma_stage gamma_stage_chk #(.SAMPLE_W(SAMPLE_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_gamma_stage.sv
`timescale 1ns/1ps
module test_gamma_stage;
  localparam int SW = 8;
  localparam int NC = 2;
  localparam int BW = SW * NC;
  localparam int AW = 9;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic s_vld_i = 1'b0, s_sop_i = 1'b0, s_eop_i = 1'b0, s_rdy_o;
  logic [BW-1:0] s_data_i = '0, m_data_o;
  logic m_vld_o, m_sop_o, m_eop_o, m_rdy_i = 1'b1;
  logic cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [SW-1:0] wdata_i = '0, rdata_o;

  gamma_stage #(.SAMPLE_W(SW), .NUM_CH(NC)) i_gamma_stage (
    .clk_i(clk), .rst_ni, .s_vld_i, .s_rdy_o, .s_data_i, .s_sop_i, .s_eop_i,
    .m_vld_o, .m_rdy_i, .m_data_o, .m_sop_o, .m_eop_o,
    .cs_i, .rd_i, .wr_i, .addr_i, .wdata_i, .rdata_o
  );

  always #2 clk = ~clk;

  typedef struct { logic [BW+1:0] v; string req; } item_t;
  item_t exp_q[$];
  item_t it;
  logic [SW-1:0] gold [256];
  int n_chk = 0, n_fail = 0, out_cnt = 0;
  bit stall_en = 0;
  logic [SW-1:0] rv;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) m_rdy_i <= stall_en ? ($urandom % 3 != 0) : 1'b1;

  // monitor
  logic [BW+1:0] prev_o, cur_o;
  bit prev_stall = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      cur_o = {m_sop_o, m_eop_o, m_data_o};
      if (prev_stall) chk(m_vld_o && cur_o == prev_o, "R9", 32'(cur_o), 32'(prev_o));
      prev_stall = m_vld_o && !m_rdy_i;
      prev_o = cur_o;
      if (m_vld_o && m_rdy_i) begin
        out_cnt++;
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected beat", 32'(cur_o), 0);
        else begin
          it = exp_q.pop_front();
          chk(cur_o == it.v, it.req, 32'(cur_o), 32'(it.v));
        end
      end
    end
  end

  function automatic logic [BW-1:0] map_beat(input logic [BW-1:0] d);
    logic [BW-1:0] r;
    for (int c = 0; c < NC; c++) r[c*SW +: SW] = gold[d[c*SW +: SW]];
    return r;
  endfunction

  task automatic send_beat(input logic [BW-1:0] d, input bit sop, input bit eop, input bit mapped, input string req);
    item_t e;
    @(negedge clk);
    s_vld_i = 1'b1; s_data_i = d; s_sop_i = sop; s_eop_i = eop;
    #1;
    while (!s_rdy_o) begin @(negedge clk); #1; end
    e.v = {sop, eop, mapped ? map_beat(d) : d};
    e.req = req;
    exp_q.push_back(e);
    @(posedge clk); #1;
    s_vld_i = 1'b0;
  endtask

  task automatic send_frame(input logic [3:0] typ, input int n, input int base, input string req);
    logic [BW-1:0] d;
    send_beat(BW'(typ), 1'b1, n == 0, 1'b0, req);
    for (int i = 0; i < n; i++) begin
      for (int c = 0; c < NC; c++) d[c*SW +: SW] = SW'(base + i*NC + c);
      send_beat(d, 1'b0, i == n-1, typ == 4'd0, req);
    end
  endtask

  task automatic reg_wr(input int a, input logic [SW-1:0] d);
    @(negedge clk);
    cs_i = 1'b1; wr_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk);
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic reg_rd(input int a, output logic [SW-1:0] d);
    @(negedge clk);
    cs_i = 1'b1; rd_i = 1'b1; addr_i = AW'(a);
    @(negedge clk);
    cs_i = 1'b0; rd_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 drain", exp_q.size(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int snap;
    for (int i = 0; i < 256; i++) gold[i] = SW'(i);
    repeat (3) @(negedge clk);
    chk(m_vld_o == 1'b0, "R1 vld in reset", m_vld_o, 0);
    rst_ni = 1'b1;
    reg_rd(0, rv);   chk(rv == 0, "R1 run bit", rv, 0);
    reg_rd(1, rv);   chk(rv == 0, "R1 status", rv, 0);
    reg_rd(2 + 8'h55, rv); chk(rv == 8'h55, "R1 identity table", rv, 8'h55);

    // R5: non-video passes while stopped
    send_frame(4'd3, 4, 8'h40, "R5");
    drain();
    reg_rd(1, rv);   chk(rv == 0, "R5 status stays 0", rv, 0);

    // R3: program a curve
    for (int i = 0; i < 256; i++) begin
      gold[i] = SW'((i * i) / 255);
      reg_wr(2 + i, gold[i]);
    end
    reg_rd(2, rv);   chk(rv == gold[0], "R3 entry 0", rv, gold[0]);
    reg_rd(257, rv); chk(rv == gold[255], "R3 entry 255", rv, gold[255]);
    reg_rd(102, rv); chk(rv == gold[100], "R3 entry 100", rv, gold[100]);

    // R2
    reg_wr(1, 8'h01);
    reg_rd(1, rv);   chk(rv == 0, "R2 status write ignored", rv, 0);
    reg_wr(0, 8'h01);
    reg_rd(0, rv);   chk(rv == 1, "R2 run bit", rv, 1);

    // R6: video frame mapped
    send_frame(4'd0, 6, 8'h10, "R6");
    drain();
    reg_rd(1, rv);   chk(rv == 1, "R8 status held between frames", rv, 1);

    // R7 with backpressure (R9)
    stall_en = 1;
    fork
      send_frame(4'd0, 16, 8'h80, "R7");
      begin
        repeat (6) @(negedge clk);
        reg_wr(0, 8'h00);
        reg_rd(1, rv); chk(rv == 1, "R7 status mid frame", rv, 1);
      end
    join
    drain();
    reg_rd(1, rv);   chk(rv == 0, "R8 status after stop", rv, 0);

    // R4: video held while stopped
    snap = out_cnt;
    fork
      send_frame(4'd0, 4, 8'hc0, "R4");
    join_none
    repeat (20) @(negedge clk);
    chk(s_vld_i && !s_rdy_o, "R4 head held", s_rdy_o, 0);
    chk(out_cnt == snap, "R4 no output", out_cnt, snap);
    reg_rd(1, rv);   chk(rv == 0, "R4 status stopped", rv, 0);
    reg_wr(0, 8'h01);
    wait fork;
    drain();
    reg_rd(1, rv);   chk(rv == 1, "R8 status rose", rv, 1);

    // R10: write while running
    for (int i = 16; i < 24; i++) begin
      gold[i] = ~SW'(i);
      reg_wr(2 + i, gold[i]);
    end
    reg_rd(2 + 20, rv); chk(rv == gold[20], "R10 readback", rv, gold[20]);
    send_frame(4'd0, 4, 16, "R10");
    drain();

    // R5 while running
    send_frame(4'd9, 3, 8'h10, "R5");
    drain();
    stall_en = 0;
    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule